// File: doc/BRIEF.md
# Addressed Serial Attenuation Receiver

This block receives a 16-bit serial control frame for a step attenuator that shares its serial lines with up to seven other attenuators. The serial data, serial clock and latch inputs come from outside and are not related to the system clock. The block brings all three through a synchronizer chain and finds their rising edges in the system clock domain. That clock must run at four times the serial bit rate or faster. While the latch input is low, every serial clock rising edge shifts one data bit into a frame register.

A latch rising edge ends the frame. At that point the block reads the three low address bits of the frame and compares them with a three-bit device address that the board wires in place. If the address matches and the reserved top bit of the attenuation byte is zero, the 7-bit attenuation code is loaded into the output register and an update strobe is raised. In every other case the stored code and the strobe stay as they were. The code counts steps of a quarter decibel, so 18.25 dB is code 73.

Top module: `serial_atten_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `atten_code` is all ones (127, the highest attenuation) and `atten_upd` is 0 until the first accepted frame.
- R2: Frame bits are numbered in arrival order, from bit 0 (first in) to bit 15 (last in). Bits 0..6 carry the attenuation code, least significant bit first. An accepted frame sets `atten_code` to the value of those bits.
- R3: Frame bits 8, 9 and 10 form the received address, with bit 8 as the LSB. A frame is accepted only when that address equals `dev_addr`.
- R4: A frame whose address differs from `dev_addr` leaves `atten_code` unchanged and raises no strobe.
- R5: Frame bits 11..15 are ignored. Any value in them gives the same result.
- R6: Frame bit 7 is reserved and must be zero. A frame with bit 7 set is rejected, and the code and strobe stay unchanged.
- R7: Serial clock rising edges that occur while `ser_le` is high shift nothing. A second latch pulse with no new bits in between accepts the same frame again.
- R8: When more than 16 bits are shifted before a latch edge, only the last 16 bits received form the frame.
- R9: On an accepted frame, `atten_upd` is high for exactly one system clock cycle, and `atten_code` takes its new value in that same cycle. Both change on the third system clock rising edge that samples `ser_le` high.
- R10: Holding `ser_le` high produces no further strobes. Exactly one decision is made for each latch rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_si | input | 1 | Serial data, sampled on the serial clock rising edge |
| ser_clk | input | 1 | Serial shift clock |
| ser_le | input | 1 | Latch: shifting while low, decision on rising edge |
| dev_addr | input | 3 | Hardwired device address |
| atten_code | output | 7 | Stored attenuation code, in quarter-decibel steps |
| atten_upd | output | 1 | One-cycle strobe for each accepted frame |

## Verification
The checker watches every cycle for four things. A strobe never lasts longer than one cycle. Whenever a strobe appears, the frame register holds a matching address and a clear reserved bit, and the output code equals the frame's code field. The code never changes without a strobe. The frame register never shifts when the latch was high at the point in the pipeline where shifting is decided.

Other behaviours can only be shown by the bench's scenarios. These include the bit order, the pass-through of the ignored address bits, the rejection cases, dropping of extra leading bits, re-latching after clock edges seen with the latch high, and the exact strobe latency. The bench checks all of them against a behavioural model, cycle by cycle.

// File: rtl/serial_atten_pkg.sv
package serial_atten_pkg;

    // Default geometry of the control frame
    localparam int unsigned FRAME_BITS   = 16;
    localparam int unsigned WORD_BITS    = 8;
    localparam int unsigned CODE_BITS    = 7;
    localparam int unsigned ADDR_BITS    = 3;
    localparam int unsigned SYNC_DEPTH   = 2;

    // Bit positions of the serial pins inside the synchronizer vector
    typedef enum int unsigned {
        PIN_SI  = 0,
        PIN_CLK = 1,
        PIN_LE  = 2
    } pin_idx_e;

    localparam int unsigned PIN_COUNT = 3;

endpackage

// File: rtl/satt_sync.sv
module satt_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.chain[STAGES-1];

endmodule

// File: rtl/satt_edge.sv
module satt_edge #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    output logic [WIDTH-1:0] rise_out
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_out = level_in & ~st_q.prev;

endmodule

// File: rtl/satt_shift.sv
module satt_shift #(
    parameter int unsigned FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame
);

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
    } shift_st_t;

    shift_st_t st_d, st_q;

    // New bits enter at the top, so the first bit of a frame ends at bit 0
    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.bits = {bit_in, st_q.bits[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame = st_q.bits;

endmodule

// File: rtl/serial_atten_rx.sv
module serial_atten_rx
    import serial_atten_pkg::*;
#(
    parameter int unsigned FRAME_W   = FRAME_BITS,
    parameter int unsigned WORD_W    = WORD_BITS,
    parameter int unsigned CODE_W    = CODE_BITS,
    parameter int unsigned ADDR_W    = ADDR_BITS,
    parameter int unsigned SYNC_N    = SYNC_DEPTH,
    parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_si,
    input  logic              ser_clk,
    input  logic              ser_le,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic [CODE_W-1:0] atten_code,
    output logic              atten_upd
);

    localparam int unsigned ADDR_LSB = WORD_W;
    localparam int unsigned ADDR_TOP = ADDR_LSB + ADDR_W;
    localparam int unsigned EDGE_W   = 2;

    logic [PIN_COUNT-1:0] pins_raw, pins_s;
    logic [EDGE_W-1:0]    lvl, rise;
    logic                 le_s, clk_rise, le_rise, shift_en;
    logic [FRAME_W-1:0]   frame_w;
    logic                 addr_hit, guard_ok, accept;
    logic                 unused_hi;

    assign pins_raw[PIN_SI]  = ser_si;
    assign pins_raw[PIN_CLK] = ser_clk;
    assign pins_raw[PIN_LE]  = ser_le;

    satt_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (SYNC_N)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_raw),
        .sync_out (pins_s)
    );

    assign le_s   = pins_s[PIN_LE];
    assign lvl[0] = pins_s[PIN_CLK];
    assign lvl[1] = le_s;

    satt_edge #(
        .WIDTH (EDGE_W)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (lvl),
        .rise_out (rise)
    );

    assign clk_rise = rise[0];
    assign le_rise  = rise[1];
    assign shift_en = clk_rise & ~le_s;

    satt_shift #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (pins_s[PIN_SI]),
        .frame    (frame_w)
    );

    // Only the low address bits are compared; the rest of the address byte is ignored
    assign addr_hit  = (frame_w[ADDR_TOP-1:ADDR_LSB] == dev_addr);
    assign unused_hi = ^frame_w[FRAME_W-1:ADDR_TOP];

    generate
        if (WORD_W > CODE_W) begin : g_guard
            assign guard_ok = (frame_w[WORD_W-1:CODE_W] == '0);
        end else begin : g_noguard
            assign guard_ok = 1'b1;
        end
    endgenerate

    assign accept = le_rise & addr_hit & guard_ok;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (accept) begin
            st_d.code = frame_w[CODE_W-1:0];
            st_d.upd  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= RESET_CODE;
            st_q.upd  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign atten_code = st_q.code;
    assign atten_upd  = st_q.upd;

endmodule

// File: rtl/serial_atten_rx_chk.sv
module serial_atten_rx_chk #(
    parameter int unsigned FRAME_W = 16,
    parameter int unsigned WORD_W  = 8,
    parameter int unsigned CODE_W  = 7,
    parameter int unsigned ADDR_W  = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ser_le,
    input logic [ADDR_W-1:0]  dev_addr,
    input logic [CODE_W-1:0]  atten_code,
    input logic               atten_upd,
    input logic [FRAME_W-1:0] frame_w
);

    // R9: the update strobe lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        atten_upd |=> !atten_upd);

    // R3: every strobe comes from a frame that carries this device's address
    a_r3_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
        atten_upd |-> (frame_w[WORD_W+ADDR_W-1:WORD_W] == dev_addr));

    // R6: no strobe for a frame whose reserved bit is set
    a_r6_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        atten_upd |-> !frame_w[WORD_W-1]);

    // R2: the output code equals the code field of the accepted frame
    a_r2_code_field: assert property (@(posedge clk) disable iff (!rst_n)
        atten_upd |-> (atten_code == frame_w[CODE_W-1:0]));

    // R4: the code never changes without a strobe
    a_r4_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(atten_code) |-> atten_upd);

    // R7: the frame register shifts only when the latch pin was low at the decision point
    a_r7_no_shift_le_high: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_w) |-> !$past(ser_le, 3));

endmodule

bind serial_atten_rx serial_atten_rx_chk #(
    .FRAME_W (FRAME_W),
    .WORD_W  (WORD_W),
    .CODE_W  (CODE_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_le     (ser_le),
    .dev_addr   (dev_addr),
    .atten_code (atten_code),
    .atten_upd  (atten_upd),
    .frame_w    (frame_w)
);

// File: tb/serial_atten_rx_test.sv
module serial_atten_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_si = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_le = 1'b0;
    logic [2:0] dev_addr = 3'd3;
    logic [6:0] atten_code;
    logic       atten_upd;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int upd_count = 0;
    string cur_req = "R1";

    // reference model state
    int  le_h[4];
    int  ck_h[4];
    int  si_h[4];
    int  bitq[$];
    int  exp_code = 127;
    int  exp_upd = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_atten_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_si     (ser_si),
        .ser_clk    (ser_clk),
        .ser_le     (ser_le),
        .dev_addr   (dev_addr),
        .atten_code (atten_code),
        .atten_upd  (atten_upd)
    );

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            le_h[i] = 0; ck_h[i] = 0; si_h[i] = 0;
        end
        bitq.delete();
        for (int i = 0; i < 16; i++) bitq.push_back(0);
        exp_code = 127;
        exp_upd  = 0;
    endtask

    initial model_clear();

    // Behavioural model: a pin level reaches the decision point two edges after capture
    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            for (int i = 3; i > 0; i--) begin
                le_h[i] = le_h[i-1]; ck_h[i] = ck_h[i-1]; si_h[i] = si_h[i-1];
            end
            le_h[0] = ser_le; ck_h[0] = ser_clk; si_h[0] = ser_si;
            exp_upd = 0;
            if (ck_h[2] == 1 && ck_h[3] == 0 && le_h[2] == 0) begin
                bitq.push_back(si_h[2]);
                void'(bitq.pop_front());
            end
            if (le_h[2] == 1 && le_h[3] == 0) begin
                int addr, code;
                addr = bitq[8] + 2 * bitq[9] + 4 * bitq[10];
                code = 0;
                for (int i = 0; i < 7; i++) code += bitq[i] << i;
                if (addr == int'(dev_addr) && bitq[7] == 0) begin
                    exp_code = code;
                    exp_upd  = 1;
                end
            end
        end
    end

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic check(string req, int actual, int expected, string what);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (atten_upd) upd_count++;
        if (rst_n) begin
            check(cur_req, int'(atten_code), exp_code, "code vs model");
            check("R9", int'(atten_upd), exp_upd, "strobe vs model");
        end
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic send_bit(logic b);
        @(negedge clk); ser_si = b; ser_clk = 1'b0;
        repeat (2) @(negedge clk);
        ser_clk = 1'b1;
        repeat (3) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_bits(logic [15:0] f);
        for (int i = 0; i < 16; i++) send_bit(f[i]);
    endtask

    task automatic pulse_le(int high_cycles);
        repeat (2) @(negedge clk);
        ser_le = 1'b1;
        repeat (high_cycles) @(negedge clk);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic frame_and_latch(logic [7:0] addr_byte, logic [7:0] att_byte);
        send_bits({addr_byte, att_byte});
        pulse_le(5);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(atten_code), 127, "code in reset");
        check("R1", int'(atten_upd), 0, "strobe in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", int'(atten_code), 127, "code after reset");

        // R2/R3: 18.25 dB (code 73) at address 3
        cur_req = "R2";
        upd_count = 0;
        frame_and_latch(8'b1010_1011, 8'd73);
        check("R2", int'(atten_code), 73, "code after matching frame");
        check("R3", upd_count, 1, "strobes for matching frame");

        // R4: address mismatch
        cur_req = "R4";
        upd_count = 0;
        frame_and_latch(8'b0000_0101, 8'd20);
        check("R4", int'(atten_code), 73, "code after mismatch");
        check("R4", upd_count, 0, "strobes after mismatch");

        // R5: upper address bits set
        cur_req = "R5";
        frame_and_latch(8'b1111_1011, 8'd5);
        check("R5", int'(atten_code), 5, "code with upper address bits set");

        // R6: reserved bit set
        cur_req = "R6";
        upd_count = 0;
        frame_and_latch(8'b0000_0011, 8'h80 | 8'd10);
        check("R6", int'(atten_code), 5, "code after reserved bit set");
        check("R6", upd_count, 0, "strobes after reserved bit set");

        // R7: clock edges with latch high shift nothing; relatch gives same frame
        cur_req = "R7";
        send_bits({8'b0000_0011, 8'd40});
        repeat (2) @(negedge clk);
        ser_le = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        @(negedge clk); ser_le = 1'b0;
        repeat (6) @(negedge clk);
        check("R7", int'(atten_code), 40, "code after clocks with latch high");
        upd_count = 0;
        pulse_le(5);
        check("R7", upd_count, 1, "relatch strobes");
        check("R7", int'(atten_code), 40, "relatch code");

        // R8: extra leading bits are dropped
        cur_req = "R8";
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        frame_and_latch(8'b0000_0011, 8'd99);
        check("R8", int'(atten_code), 99, "code after long frame");

        // R10: long latch high gives one strobe
        cur_req = "R10";
        upd_count = 0;
        send_bits({8'b0100_0011, 8'd64});
        pulse_le(40);
        check("R10", upd_count, 1, "strobes for long latch");
        check("R10", int'(atten_code), 64, "code for long latch");

        // R3: address corners 7 and 0
        cur_req = "R3";
        dev_addr = 3'd7;
        frame_and_latch(8'b0000_0111, 8'd0);
        check("R3", int'(atten_code), 0, "code at address 7");
        dev_addr = 3'd0;
        frame_and_latch(8'b0000_0111, 8'd127);
        check("R3", int'(atten_code), 0, "address 7 frame at device 0");
        frame_and_latch(8'b0000_0000, 8'd127);
        check("R3", int'(atten_code), 127, "code at address 0");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule